// File: doc/BRIEF.md
# Power-Down Wake Sequencer

This block governs a small processor core's deepest sleep state. Software asks for sleep with a one-cycle request strobe. That strobe is the decoded write of 1 to bit 1 of the power-control register, and it is the last instruction the core retires. On that request the sequencer removes the core clock enable and tells the port logic to freeze its pins at the values in their output registers. The sequencer itself runs on a clock that never stops, so it keeps watching the wake inputs while the core is gated.

Three kinds of event end the sleep: the external reset pin, any external interrupt line whose own enable is set, and the ring-detect line when its enable is set. The two interrupt-type sources also need the global interrupt enable. After a wake, a fixed warm-up interval of `WARM_CYCLES` oscillator clocks gives the crystal time to settle. A reset-type wake then holds the core in reset for a few more cycles, so it restarts from address zero. An interrupt-type wake sends a resume indication, and the core then enters its service routine and later returns to the instruction after the sleep request. If the RC-select bit is set when the wake is taken, the core is clocked at once from the fast internal RC oscillator. In that case it resumes immediately, and at the end of the warm-up the clock moves back to the crystal.

Top module: `pdw_seq`

## Requirements
- R1: While running, a cycle with `pd_req_i`=1 and `ext_rst_i`=0 enters sleep: from the next cycle `core_clk_en_o`=0 and `port_hold_o`=1. `pd_req_i` has no effect in any other state.
- R2: While asleep, `core_clk_en_o` stays 0, `port_hold_o` stays 1 and `int_rst_o` stays 0 until a wake condition is sampled.
- R3: `ext_rst_i`=1 while asleep wakes the block whatever the enable bits are.
- R4: External line g (`xirq_i[g]`) wakes the block only if `xirq_en_i[g]`=1 and `gie_i`=1. `ring_i` wakes it only if `ring_en_i`=1 and `gie_i`=1. The sources are sampled as levels.
- R5: The warm-up lasts exactly `WARM_CYCLES` cycles, starting in the cycle after the wake is sampled. `warm_done_o` is a one-cycle pulse in its last cycle. The counter is cleared on sleep entry, so every warm-up has full length.
- R6: After a reset-caused wake, `int_rst_o`=1 throughout the warm-up and for `RST_HOLD` cycles after it, then 0. `irq_resume_o` stays 0.
- R7: After an interrupt-caused wake with `rc_sel_i`=0, `core_clk_en_o`=0 and `port_hold_o`=1 during the warm-up. `irq_resume_o` is a one-cycle pulse in the same cycle as `warm_done_o`.
- R8: With `rc_sel_i`=1 in the wake-sampling cycle, the warm-up runs with `core_clk_en_o`=1, `rc_clk_sel_o`=1 and `port_hold_o`=0. An interrupt wake pulses `irq_resume_o` in the first warm-up cycle. After `warm_done_o`, `rc_clk_sel_o`=0.
- R9: If reset and an enabled interrupt are sampled in the same cycle, the wake is treated as reset-caused.
- R10: After power-on reset (`rst_n`=0) the block is running: `core_clk_en_o`=1, and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running wake-detection and counting clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pd_req_i | input | 1 | Sleep request strobe from the power-control register write |
| rc_sel_i | input | 1 | RC-oscillator wake select bit |
| ext_rst_i | input | 1 | External reset pin level, active high |
| gie_i | input | 1 | Global interrupt enable |
| xirq_i | input | N_XIRQ | External interrupt line levels |
| xirq_en_i | input | N_XIRQ | Per-line interrupt enables |
| ring_i | input | 1 | Ring-detect event level |
| ring_en_i | input | 1 | Ring-detect interrupt enable |
| core_clk_en_o | output | 1 | Core clock enable |
| rc_clk_sel_o | output | 1 | Core clock taken from the RC oscillator |
| port_hold_o | output | 1 | Freeze port pins at their output-register values |
| int_rst_o | output | 1 | Internal reset request to the core |
| irq_resume_o | output | 1 | One-cycle pulse: core may take the wake interrupt |
| warm_done_o | output | 1 | One-cycle pulse at the end of the warm-up (clock hand-over) |

## Verification
The bench sweeps every wake source against every setting of its own enable, the global enable and the RC-select bit. A design that ignores the global enable, or wires an enable to the wrong line, either wakes when it should stay asleep or stays stuck asleep. Each wake is followed cycle by cycle against a computed timeline. This catches a warm-up that is one cycle short or long, a resume pulse that comes at the crystal hand-over instead of the start in RC mode, and a reset hold that is dropped or stretched. Simultaneous reset and interrupt checks the priority, where a wrong order would give a resume pulse with no reset. Sleep requests made during warm-up, or while the reset pin is high, must leave the timeline unchanged.

// File: rtl/pdw_pkg.sv
`timescale 1ns/1ps
package pdw_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WARM  = 2'd2,
    ST_RHOLD = 2'd3
  } pdw_state_e;

  typedef enum logic {
    CAUSE_IRQ = 1'b0,
    CAUSE_RST = 1'b1
  } pdw_cause_e;

  // last cycle of an interval of len cycles counted from zero
  function automatic logic cnt_is_last(input int unsigned cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // any gated interrupt-type wake request
  function automatic logic irq_hit(input logic any_src, input logic gie);
    return any_src & gie;
  endfunction

endpackage

// File: rtl/pdw_wake_detect.sv
`timescale 1ns/1ps
module pdw_wake_detect #(
  parameter int N_XIRQ = 2
) (
  input  logic              ext_rst_i,
  input  logic              gie_i,
  input  logic [N_XIRQ-1:0] xirq_i,
  input  logic [N_XIRQ-1:0] xirq_en_i,
  input  logic              ring_i,
  input  logic              ring_en_i,
  output logic              wake_rst_o,
  output logic              wake_irq_o
);
  import pdw_pkg::*;

  localparam int N_SRC = N_XIRQ + 1;

  logic [N_SRC-1:0] src_hit;

  genvar g;
  generate
    for (g = 0; g < N_XIRQ; g++) begin : g_xirq
      assign src_hit[g] = xirq_i[g] & xirq_en_i[g];
    end
  endgenerate
  assign src_hit[N_XIRQ] = ring_i & ring_en_i;

  assign wake_rst_o = ext_rst_i;
  assign wake_irq_o = irq_hit(|src_hit, gie_i);

endmodule

// File: rtl/pdw_warm_counter.sv
`timescale 1ns/1ps
module pdw_warm_counter #(
  parameter int WIDTH = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pdw_out_decode.sv
`timescale 1ns/1ps
module pdw_out_decode (
  input  pdw_pkg::pdw_state_e st_i,
  input  pdw_pkg::pdw_cause_e cause_i,
  input  logic                rc_mode_i,
  input  logic                cnt_zero_i,
  input  logic                warm_last_i,
  output logic                core_clk_en_o,
  output logic                rc_clk_sel_o,
  output logic                port_hold_o,
  output logic                int_rst_o,
  output logic                irq_resume_o,
  output logic                warm_done_o
);
  import pdw_pkg::*;

  logic in_warm;
  logic irq_cause;

  assign in_warm   = (st_i == ST_WARM);
  assign irq_cause = (cause_i == CAUSE_IRQ);

  always_comb begin
    core_clk_en_o = (st_i == ST_RUN) || (st_i == ST_RHOLD) || (in_warm && rc_mode_i);
    rc_clk_sel_o  = in_warm && rc_mode_i;
    port_hold_o   = (st_i == ST_SLEEP) || (in_warm && !rc_mode_i);
    int_rst_o     = (in_warm && !irq_cause) || (st_i == ST_RHOLD);
    irq_resume_o  = in_warm && irq_cause && (rc_mode_i ? cnt_zero_i : warm_last_i);
    warm_done_o   = warm_last_i;
  end
endmodule

// File: rtl/pdw_seq.sv
`timescale 1ns/1ps
module pdw_seq #(
  parameter int N_XIRQ      = 2,
  parameter int WARM_CYCLES = 65536,
  parameter int RST_HOLD    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_req_i,
  input  logic              rc_sel_i,
  input  logic              ext_rst_i,
  input  logic              gie_i,
  input  logic [N_XIRQ-1:0] xirq_i,
  input  logic [N_XIRQ-1:0] xirq_en_i,
  input  logic              ring_i,
  input  logic              ring_en_i,
  output logic              core_clk_en_o,
  output logic              rc_clk_sel_o,
  output logic              port_hold_o,
  output logic              int_rst_o,
  output logic              irq_resume_o,
  output logic              warm_done_o
);
  import pdw_pkg::*;

  localparam int unsigned SPAN  = max_u(WARM_CYCLES, RST_HOLD);
  localparam int          CNT_W = $clog2(SPAN + 1);

  pdw_state_e       st_q, st_d;
  pdw_cause_e       cause_q;
  logic             rc_mode_q;
  logic [CNT_W-1:0] cnt;

  // named internal events, also used by the checker
  logic wake_rst, wake_irq;
  logic pd_accept, wake_take, warm_last, hold_last, cnt_zero;

  pdw_wake_detect #(.N_XIRQ(N_XIRQ)) u_wake (
    .ext_rst_i (ext_rst_i),
    .gie_i     (gie_i),
    .xirq_i    (xirq_i),
    .xirq_en_i (xirq_en_i),
    .ring_i    (ring_i),
    .ring_en_i (ring_en_i),
    .wake_rst_o(wake_rst),
    .wake_irq_o(wake_irq)
  );

  assign pd_accept = (st_q == ST_RUN) && pd_req_i && !ext_rst_i;
  assign wake_take = (st_q == ST_SLEEP) && (wake_rst || wake_irq);
  assign cnt_zero  = (cnt == '0);
  assign warm_last = (st_q == ST_WARM)  && cnt_is_last(32'(cnt), WARM_CYCLES);
  assign hold_last = (st_q == ST_RHOLD) && cnt_is_last(32'(cnt), RST_HOLD);

  pdw_warm_counter #(.WIDTH(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr_i(pd_accept || wake_take || warm_last),
    .inc_i((st_q == ST_WARM) || (st_q == ST_RHOLD)),
    .cnt_o(cnt)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:   if (pd_accept) st_d = ST_SLEEP;
      ST_SLEEP: if (wake_take) st_d = ST_WARM;
      ST_WARM:  if (warm_last) st_d = (cause_q == CAUSE_RST) ? ST_RHOLD : ST_RUN;
      ST_RHOLD: if (hold_last) st_d = ST_RUN;
      default:  st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_RUN;
      cause_q   <= CAUSE_IRQ;
      rc_mode_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (wake_take) begin
        cause_q   <= wake_rst ? CAUSE_RST : CAUSE_IRQ;
        rc_mode_q <= rc_sel_i;
      end
    end
  end

  pdw_out_decode u_out (
    .st_i         (st_q),
    .cause_i      (cause_q),
    .rc_mode_i    (rc_mode_q),
    .cnt_zero_i   (cnt_zero),
    .warm_last_i  (warm_last),
    .core_clk_en_o(core_clk_en_o),
    .rc_clk_sel_o (rc_clk_sel_o),
    .port_hold_o  (port_hold_o),
    .int_rst_o    (int_rst_o),
    .irq_resume_o (irq_resume_o),
    .warm_done_o  (warm_done_o)
  );

endmodule

// File: rtl/pdw_chk.sv
`timescale 1ns/1ps
module pdw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] st,
  input logic       pd_accept,
  input logic       wake_rst,
  input logic       wake_irq,
  input logic       core_clk_en_o,
  input logic       rc_clk_sel_o,
  input logic       port_hold_o,
  input logic       int_rst_o,
  input logic       irq_resume_o,
  input logic       warm_done_o
);
  import pdw_pkg::*;

  logic asleep;
  assign asleep = (st == 2'(ST_SLEEP));

  p_sleep_gates_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pd_accept |=> (port_hold_o && !core_clk_en_o));

  p_stay_asleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !wake_rst && !wake_irq) |=> (port_hold_o && !core_clk_en_o && !int_rst_o));

  p_rst_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && wake_rst) |=> (int_rst_o && !irq_resume_o));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    warm_done_o |=> !warm_done_o);

  p_handover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    warm_done_o |=> (core_clk_en_o && !rc_clk_sel_o));

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_resume_o, int_rst_o}));

endmodule

bind pdw_seq pdw_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .st           (st_q),
  .pd_accept    (pd_accept),
  .wake_rst     (wake_rst),
  .wake_irq     (wake_irq),
  .core_clk_en_o(core_clk_en_o),
  .rc_clk_sel_o (rc_clk_sel_o),
  .port_hold_o  (port_hold_o),
  .int_rst_o    (int_rst_o),
  .irq_resume_o (irq_resume_o),
  .warm_done_o  (warm_done_o)
);

// File: tb/pdw_seq_tb.sv
`timescale 1ns/1ps
module pdw_seq_tb_top;
  localparam int NX = 2;
  localparam int W  = 16;
  localparam int H  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 0, rc_sel = 0, ext_rst = 0, gie = 0, ring = 0, ring_en = 0;
  logic [NX-1:0] xirq = '0, xirq_en = '0;
  logic core_en, rc_clk, hold, irst, ires, wdone;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pdw_seq #(.N_XIRQ(NX), .WARM_CYCLES(W), .RST_HOLD(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .pd_req_i(pd_req), .rc_sel_i(rc_sel),
    .ext_rst_i(ext_rst), .gie_i(gie), .xirq_i(xirq), .xirq_en_i(xirq_en),
    .ring_i(ring), .ring_en_i(ring_en),
    .core_clk_en_o(core_en), .rc_clk_sel_o(rc_clk), .port_hold_o(hold),
    .int_rst_o(irst), .irq_resume_o(ires), .warm_done_o(wdone)
  );

  // outputs packed as {core_en, rc_clk, hold, irst, ires, wdone}
  task automatic chk(input logic [5:0] exp, input string tag);
    logic [5:0] act;
    act = {core_en, rc_clk, hold, irst, ires, wdone};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  localparam logic [5:0] RUNV   = 6'b100000;
  localparam logic [5:0] SLEEPV = 6'b001000;

  // expected outputs k cycles after the wake-sampling edge
  function automatic logic [5:0] expect_at(int k, bit is_rst, bit rc);
    logic [5:0] e;
    if (k <= W) begin
      e[5] = rc;  e[4] = rc;  e[3] = !rc;  e[2] = is_rst;
      e[1] = !is_rst && (rc ? (k == 1) : (k == W));
      e[0] = (k == W);
    end else if (is_rst && k <= W + H) e = 6'b100100;
    else e = RUNV;
    return e;
  endfunction

  task automatic clear_srcs();
    xirq = '0; ring = 0; ext_rst = 0;
  endtask

  task automatic enter_sleep(input string tag);
    @(negedge clk); pd_req = 1;
    @(negedge clk); pd_req = 0;
    chk(SLEEPV, tag);
  endtask

  // caller raised the wake condition at the current negedge
  task automatic follow_wake(input bit is_rst, input bit rc, input string tag);
    for (int k = 1; k <= W + H + 2; k++) begin
      @(negedge clk);
      chk(expect_at(k, is_rst, rc), tag);
      if (k == 1) clear_srcs();
      pd_req = (k == 2);   // request during warm-up must be ignored (R1)
    end
    pd_req = 0;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(RUNV, "R10 reset state");
    rst_n = 1;
    @(negedge clk);
    chk(RUNV, "R10 after release");

    // request with reset pin high is ignored (R1)
    ext_rst = 1; pd_req = 1;
    @(negedge clk); pd_req = 0; ext_rst = 0;
    @(negedge clk);
    chk(RUNV, "R1 request blocked by reset pin");

    // sweep: source x own enable x global enable x rc select (R4, R5, R7, R8)
    for (int src = 0; src <= NX; src++) begin
      for (int en = 0; en < 2; en++) begin
        for (int ge = 0; ge < 2; ge++) begin
          for (int rc = 0; rc < 2; rc++) begin
            enter_sleep("R1 enter sleep");
            @(negedge clk);
            gie = ge[0]; rc_sel = rc[0];
            xirq_en = '0; ring_en = 0;
            if (src < NX) begin xirq_en[src] = en[0]; xirq[src] = 1; end
            else begin ring_en = en[0]; ring = 1; end
            if (en == 1 && ge == 1) begin
              follow_wake(1'b0, rc[0], "R4 R5 R7 R8 irq wake");
            end else begin
              repeat (3) begin
                @(negedge clk);
                chk(SLEEPV, "R2 R4 masked source keeps sleep");
              end
              clear_srcs(); ext_rst = 1;
              follow_wake(1'b1, rc[0], "R3 R6 reset wake");
            end
          end
        end
      end
    end

    // simultaneous reset and enabled interrupt -> reset (R9)
    for (int rc = 0; rc < 2; rc++) begin
      enter_sleep("R1 enter sleep");
      @(negedge clk);
      gie = 1; xirq_en = '1; rc_sel = rc[0];
      xirq[0] = 1; ext_rst = 1;
      follow_wake(1'b1, rc[0], "R9 reset priority");
    end

    // reset wake with all enables cleared (R3)
    enter_sleep("R1 enter sleep");
    @(negedge clk);
    gie = 0; xirq_en = '0; ring_en = 0; rc_sel = 0; ext_rst = 1;
    follow_wake(1'b1, 1'b0, "R3 reset without enables");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule